// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block connects a simple single-word host request port to a single-data-rate synchronous DRAM with four banks and a 16-bit data bus. After reset it brings the memory up with a precharge of every bank, two refresh cycles and a mode-register write, and only then raises `ready`. From that point it turns each accepted host request into the right chain of activate, precharge and column commands. It keeps one open row per bank, so accesses that hit the open row skip the activate. It also schedules auto-refresh so that 4096 refreshes fall within every 64 ms.

The memory is programmed for single-word bursts. Read data comes back on `rdata` with a one-cycle `rvalid` pulse, in request order. A per-request flag selects a column command with auto-precharge. Without it the row stays open until a conflicting access or a refresh closes it. The `cfg_cas3` input picks one of two timing profiles while reset is held: CAS latency, row-to-column delay and precharge time are all 3 cycles, or all 2 cycles.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: After reset release the first commands are a precharge with address bit 10 high, then at least two auto-refresh commands, then a mode-register write whose address bits [6:4] hold the CAS latency and bits [3:0] are 0000 (burst of one, sequential). `ready` stays low until that write has been issued.
- R2: `cfg_cas3`, sampled while `rst_n` is low, selects the profile: 1 gives CAS latency, row-to-column delay and precharge time of 3 cycles each, 0 gives 2 cycles each. No read or write reaches a bank earlier than the row-to-column delay after its activate.
- R3: `rdata` carries the value on `sd_dq_i` at the clock edge that comes exactly CAS-latency cycles after the edge at which the memory samples the read command. `rvalid` is high for that one cycle only.
- R4: The host address is {bank[22:21], row[20:9], column[8:0]}. The bank goes to `sd_ba`, the row to `sd_a` on activate, and the column to `sd_a[8:0]` on read or write.
- R5: A request to a bank whose open row matches the requested row issues its read or write with no activate before it.
- R6: A request to a bank whose open row differs first precharges that bank alone (`sd_a[10]` low), waits the precharge time, then activates the new row. Activates only go to banks that are closed.
- R7: A request with `req_ap` high issues its column command with `sd_a[10]` high. The bank counts as closed afterwards, and the next access to it activates without an explicit precharge.
- R8: A refresh request comes due every floor(CLK_MHZ*15625/1000) cycles and is served ahead of new host requests once the current access ends. Any open banks are first closed by one precharge with `sd_a[10]` high. Refresh commands are never more than that period plus a short service delay apart.
- R9: On a write, `sd_dq_o` carries the write data with `sd_dq_oe` high for that cycle only, and `sd_dqm[i]` is the inverse of `req_be[i]` (bit 0 lower byte, bit 1 upper byte). In every other cycle `sd_dqm` is 00 and `sd_dq_oe` is low.
- R10: Commands are {cs_n, ras_n, cas_n, we_n} = 0111 no-op, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 auto-refresh, 0000 mode write. During reset the pins show no-op with `sd_dq_oe` low.
- R11: A request is accepted at a rising edge where `req` and `ready` are both high. `ready` is low while an access, refresh or timing wait is in progress. Requests are carried out in order, one column command each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| cfg_cas3 | input | 1 | Timing profile select, sampled during reset |
| req | input | 1 | Host request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Close the row after this access |
| req_addr | input | 23 | {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower byte |
| ready | output | 1 | Request can be accepted this cycle |
| rdata | output | 16 | Read data |
| rvalid | output | 1 | Read data valid pulse |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Multiplexed address |
| sd_dqm | output | 2 | Byte masks, high = masked |
| sd_dq_o | output | 16 | Write data to memory |
| sd_dq_oe | output | 1 | Drive enable for write data |
| sd_dq_i | input | 16 | Read data from memory |

## Verification
The host sequence is run under both latency profiles. It includes a write followed by a read of the same row, which shows the open-row hit apart from a fresh activate. A read to another row of an open bank checks the single-bank precharge and activate path. A pair of accesses with auto-precharge shows that the row is closed without an explicit precharge. Partial byte enables confirm that each byte mask gates only its own lane. A long run of back-to-back mixed requests across banks and rows shows that refresh keeps its interval and wins over host traffic, and an idle stretch shows refresh running without requests.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_ACT = 4'b0011,
      CMD_WR  = 4'b0100,
      CMD_RD  = 4'b0101,
      CMD_NOP = 4'b0111
   } sdc_cmd_e;

   typedef enum logic [1:0] {
      ST_PWR  = 2'd0,
      ST_IDLE = 2'd1,
      ST_ACC  = 2'd2
   } sdc_state_e;

   localparam int NUM_BANKS = 4;
   localparam int MAX_CL    = 3;
endpackage

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
   parameter int PERIOD = 1562,
   localparam int CW    = $clog2(PERIOD + 1)
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= CW'(PERIOD - 1);
         tick_o <= 1'b0;
      end else if (cnt == '0) begin
         cnt    <= CW'(PERIOD - 1);
         tick_o <= 1'b1;
      end else begin
         cnt    <= cnt - 1'b1;
         tick_o <= 1'b0;
      end
   end
endmodule

// File: rtl/sdc_bank_row.sv
module sdc_bank_row #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic             clr_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_o <= 1'b0;
         row_o  <= '0;
      end else if (clr_i) begin
         open_o <= 1'b0;
      end else if (set_i) begin
         open_o <= 1'b1;
         row_o  <= row_i;
      end
   end
endmodule

// File: rtl/sdc_rd_capture.sv
module sdc_rd_capture #(
   parameter int DQ_W   = 16,
   parameter int MAX_CL = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_go_i,
   input  logic [1:0]      lat_i,
   input  logic [DQ_W-1:0] dq_i,
   output logic [DQ_W-1:0] rdata_o,
   output logic            rvalid_o
);
   logic [MAX_CL-1:0] sh;
   logic              tap;

   assign tap = sh[lat_i - 2'd1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '0;
         rvalid_o <= 1'b0;
         rdata_o  <= '0;
      end else begin
         sh       <= {sh[MAX_CL-2:0], rd_go_i};
         rvalid_o <= tap;
         if (tap) rdata_o <= dq_i;
      end
   end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
   import sdc_pkg::*;
#(
   parameter int ROW_W    = 12,
   parameter int COL_W    = 9,
   parameter int DQ_W     = 16,
   parameter int CLK_MHZ  = 100,
   parameter int INIT_CYC = 20000,
   parameter int TRFC     = 7,
   parameter int TMRD     = 2,
   localparam int ADDR_W  = 2 + ROW_W + COL_W,
   localparam int BE_W    = DQ_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cas3,
   input  logic              req,
   input  logic              req_we,
   input  logic              req_ap,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DQ_W-1:0]   req_wdata,
   input  logic [BE_W-1:0]   req_be,
   output logic              ready,
   output logic [DQ_W-1:0]   rdata,
   output logic              rvalid,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [1:0]        sd_ba,
   output logic [ROW_W-1:0]  sd_a,
   output logic [BE_W-1:0]   sd_dqm,
   output logic [DQ_W-1:0]   sd_dq_o,
   output logic              sd_dq_oe,
   input  logic [DQ_W-1:0]   sd_dq_i
);
   localparam int REFI  = (CLK_MHZ * 15625) / 1000;
   localparam int CNT_W = ($clog2(INIT_CYC + 1) > 5) ? $clog2(INIT_CYC + 1) : 5;

   // elaboration-time parameter checks
   if (ROW_W < 11) begin : g_bad_row
      $error("ROW_W must leave room for address bit 10");
   end
   if (COL_W > 10) begin : g_bad_col
      $error("COL_W must stay below address bit 10");
   end
   if (DQ_W % 8 != 0) begin : g_bad_dq
      $error("DQ_W must be a whole number of bytes");
   end
   if (REFI <= TRFC + 32) begin : g_bad_refi
      $error("refresh period too short for the clock");
   end

   sdc_state_e          st;
   sdc_cmd_e            cmd;
   logic [1:0]          istep;
   logic [CNT_W-1:0]    wcnt;
   logic [CNT_W-1:0]    prof;
   logic                cl3;
   logic                ref_tick, ref_pend, rd_go;
   logic [1:0]          bank_q;
   logic [ROW_W-1:0]    row_q;
   logic [COL_W-1:0]    col_q;
   logic                we_q, ap_q;
   logic [DQ_W-1:0]     wd_q;
   logic [BE_W-1:0]     be_q;
   logic [NUM_BANKS-1:0] b_open, open_set, close_set;
   logic [ROW_W-1:0]    b_row [NUM_BANKS];

   assign prof  = cl3 ? CNT_W'(3) : CNT_W'(2);
   assign ready = (st == ST_IDLE) && (wcnt == '0) && !ref_pend;
   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

   sdc_refresh_timer #(.PERIOD(REFI)) u_refi (
      .clk(clk), .rst_n(rst_n), .tick_o(ref_tick));

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      sdc_bank_row #(.ROW_W(ROW_W)) u_row (
         .clk(clk), .rst_n(rst_n),
         .set_i(open_set[g]), .clr_i(close_set[g]), .row_i(row_q),
         .open_o(b_open[g]), .row_o(b_row[g]));
   end

   sdc_rd_capture #(.DQ_W(DQ_W), .MAX_CL(MAX_CL)) u_cap (
      .clk(clk), .rst_n(rst_n), .rd_go_i(rd_go),
      .lat_i(cl3 ? 2'd3 : 2'd2), .dq_i(sd_dq_i),
      .rdata_o(rdata), .rvalid_o(rvalid));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_PWR;
         istep     <= '0;
         wcnt      <= CNT_W'(INIT_CYC - 1);
         cl3       <= cfg_cas3;
         cmd       <= CMD_NOP;
         ref_pend  <= 1'b0;
         rd_go     <= 1'b0;
         open_set  <= '0;
         close_set <= '0;
         sd_ba     <= '0;
         sd_a      <= '0;
         sd_dqm    <= '0;
         sd_dq_o   <= '0;
         sd_dq_oe  <= 1'b0;
         bank_q    <= '0;
         row_q     <= '0;
         col_q     <= '0;
         we_q      <= 1'b0;
         ap_q      <= 1'b0;
         wd_q      <= '0;
         be_q      <= '0;
      end else begin
         cmd       <= CMD_NOP;
         rd_go     <= 1'b0;
         open_set  <= '0;
         close_set <= '0;
         sd_dqm    <= '0;
         sd_dq_oe  <= 1'b0;
         if (ref_tick) ref_pend <= 1'b1;
         if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
         end else begin
            unique case (st)
               ST_PWR: begin
                  if (istep == 2'd0) begin
                     cmd       <= CMD_PRE;
                     sd_a      <= '0;
                     sd_a[10]  <= 1'b1;
                     wcnt      <= prof - 1'b1;
                  end else if (istep != 2'd3) begin
                     cmd       <= CMD_REF;
                     wcnt      <= CNT_W'(TRFC - 1);
                  end else begin
                     cmd       <= CMD_MRS;
                     sd_ba     <= '0;
                     sd_a      <= ROW_W'({prof[2:0], 4'b0000});
                     wcnt      <= CNT_W'(TMRD - 1);
                     st        <= ST_IDLE;
                  end
                  istep <= istep + 2'd1;
               end
               ST_IDLE: begin
                  if (ref_pend) begin
                     if (|b_open) begin
                        cmd       <= CMD_PRE;
                        sd_a      <= '0;
                        sd_a[10]  <= 1'b1;
                        close_set <= '1;
                        wcnt      <= prof - 1'b1;
                     end else begin
                        cmd       <= CMD_REF;
                        ref_pend  <= 1'b0;
                        wcnt      <= CNT_W'(TRFC - 1);
                     end
                  end else if (req) begin
                     bank_q <= req_addr[ADDR_W-1 -: 2];
                     row_q  <= req_addr[COL_W +: ROW_W];
                     col_q  <= req_addr[COL_W-1:0];
                     we_q   <= req_we;
                     ap_q   <= req_ap;
                     wd_q   <= req_wdata;
                     be_q   <= req_be;
                     st     <= ST_ACC;
                  end
               end
               default: begin
                  sd_ba <= bank_q;
                  if (!b_open[bank_q]) begin
                     cmd              <= CMD_ACT;
                     sd_a             <= row_q;
                     open_set[bank_q] <= 1'b1;
                     wcnt             <= prof - 1'b1;
                  end else if (b_row[bank_q] != row_q) begin
                     cmd               <= CMD_PRE;
                     sd_a              <= '0;
                     close_set[bank_q] <= 1'b1;
                     wcnt              <= prof - 1'b1;
                  end else begin
                     sd_a     <= ROW_W'(col_q);
                     sd_a[10] <= ap_q;
                     close_set[bank_q] <= ap_q;
                     if (we_q) begin
                        cmd      <= CMD_WR;
                        sd_dq_o  <= wd_q;
                        sd_dq_oe <= 1'b1;
                        sd_dqm   <= ~be_q;
                        wcnt     <= CNT_W'(1) + (ap_q ? prof : '0);
                     end else begin
                        cmd   <= CMD_RD;
                        rd_go <= 1'b1;
                        wcnt  <= prof + (ap_q ? prof : '0);
                     end
                     st <= ST_IDLE;
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/sdram_seq_ctrl_chk.sv
module sdram_seq_ctrl_chk
   import sdc_pkg::*;
#(
   parameter int BE_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cl3,
   input logic            ready,
   input logic            rvalid,
   input logic [3:0]      cmd,
   input logic            dq_oe,
   input logic [BE_W-1:0] dqm
);
   logic is_rd, is_wr, is_act, is_pre, is_nop;
   assign is_rd  = (cmd == CMD_RD);
   assign is_wr  = (cmd == CMD_WR);
   assign is_act = (cmd == CMD_ACT);
   assign is_pre = (cmd == CMD_PRE);
   assign is_nop = (cmd == CMD_NOP);

   assert_rd_lat3_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && cl3) |-> $past(is_rd, 4));
   assert_rd_lat2_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && !cl3) |-> $past(is_rd, 3));
   assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |=> !rvalid);
   assert_act_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |=> is_nop);
   assert_pre_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |=> is_nop);
   assert_oe_only_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> is_wr);
   assert_mask_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !is_wr |-> (dqm == '0));
   assert_ready_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> is_nop);
endmodule

bind sdram_seq_ctrl sdram_seq_ctrl_chk #(.BE_W(BE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cl3(cl3), .ready(ready), .rvalid(rvalid),
   .cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
   .dq_oe(sd_dq_oe), .dqm(sd_dqm));

// File: tb/sdram_seq_ctrl_tb.sv
module sdram_seq_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int REFI       = 1562;
   localparam int SLACK      = 40;

   logic        clk = 1'b0, rst_n = 1'b0, cfg_cas3 = 1'b0;
   logic        req = 1'b0, req_we = 1'b0, req_ap = 1'b0;
   logic [22:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        ready, rvalid;
   logic [15:0] rdata;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]  sd_ba;
   logic [11:0] sd_a;
   logic [1:0]  sd_dqm;
   logic [15:0] sd_dq_o;
   logic        sd_dq_oe;
   logic [15:0] sd_dq_i = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_seq_ctrl #(.INIT_CYC(40)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_cas3(cfg_cas3), .req(req), .req_we(req_we),
      .req_ap(req_ap), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .ready(ready), .rdata(rdata), .rvalid(rvalid), .sd_cs_n(sd_cs_n),
      .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
      .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_o(sd_dq_o), .sd_dq_oe(sd_dq_oe),
      .sd_dq_i(sd_dq_i));

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // ---------------- behavioural memory and host model ----------------
   typedef struct { bit we; bit ap; int bank; int row; int col; logic [15:0] d; logic [1:0] be; } acc_t;
   typedef struct { int t; logic [15:0] d; } drv_t;
   acc_t        acc_q[$];
   drv_t        drv_q[$];
   logic [15:0] rexp_q[$];
   int          rdue_q[$];
   logic [15:0] mem [int];
   logic [15:0] shadow [int];

   int n = 0, cl = 2, last_ref = 0, init_refs = 0;
   int n_act = 0, n_pre = 0, n_ref = 0;
   bit init_pre = 0, mrs_done = 0;
   bit [3:0] opened = '0;
   int orow [4], t_act [4], t_rdy [4];

   function automatic logic [15:0] dflt(int a);
      return 16'(a) ^ 16'hA5A5;
   endfunction

   function automatic int pack(int bank, int row, int col);
      return bank * (1 << 21) + row * 512 + col;
   endfunction

   always @(negedge clk) begin
      int b, due, ad, tmax;
      logic [15:0] e, v;
      acc_t a;
      n++;
      if (rst_n) begin
         while (drv_q.size() > 0 && drv_q[0].t <= n) begin
            sd_dq_i = drv_q[0].d;
            void'(drv_q.pop_front());
         end
         if (ready && !mrs_done) check(0, "R1 ready before mode write", 1, 0);
         if (rvalid) begin
            if (rdue_q.size() == 0) check(0, "R3 rvalid with no read", 1, 0);
            else begin
               due = rdue_q.pop_front();
               e   = rexp_q.pop_front();
               check(n == due, "R3 read latency", n, due);
               check(rdata == e, "R3 read data", rdata, e);
            end
         end
         b = int'(sd_ba);
         case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
            4'b0111: ;
            4'b0010: begin
               n_pre++;
               if (sd_a[10]) begin
                  for (int i = 0; i < 4; i++) begin opened[i] = 0; t_rdy[i] = n + cl; end
               end else begin
                  opened[b] = 0; t_rdy[b] = n + cl;
               end
               if (!mrs_done) init_pre = 1;
            end
            4'b0011: begin
               n_act++;
               check(mrs_done && !opened[b] && n >= t_rdy[b],
                     "R6 activate needs closed bank and precharge time", n, t_rdy[b]);
               opened[b] = 1; orow[b] = int'(sd_a); t_act[b] = n;
            end
            4'b0100, 4'b0101: begin
               check(opened[b] && n >= t_act[b] + cl, "R2 column command after row delay",
                     n, t_act[b] + cl);
               if (acc_q.size() == 0) check(0, "R11 column command with no request", 0, 1);
               else begin
                  a  = acc_q.pop_front();
                  ad = pack(b, orow[b], int'(sd_a[8:0]));
                  check(ad == pack(a.bank, a.row, a.col), "R4 bank row column fields",
                        ad, pack(a.bank, a.row, a.col));
                  check(a.we == !sd_we_n, "R11 command kind in order", !sd_we_n, a.we);
                  check(sd_a[10] == a.ap, "R7 auto-precharge bit", sd_a[10], a.ap);
                  v = mem.exists(ad) ? mem[ad] : dflt(ad);
                  if (!sd_we_n) begin
                     check(sd_dq_oe && sd_dq_o == a.d && sd_dqm == ~a.be,
                           "R9 write data and byte masks", {sd_dq_oe, sd_dqm, sd_dq_o},
                           {1'b1, ~a.be, a.d});
                     if (!sd_dqm[0]) v[7:0]  = sd_dq_o[7:0];
                     if (!sd_dqm[1]) v[15:8] = sd_dq_o[15:8];
                     mem[ad] = v;
                  end else begin
                     check(!sd_dq_oe && sd_dqm == 2'b00, "R9 read leaves masks clear",
                           {sd_dq_oe, sd_dqm}, 0);
                     drv_q.push_back('{n + cl, v});
                     rdue_q.push_back(n + 1 + cl);
                  end
                  if (a.ap) begin
                     opened[b] = 0;
                     t_rdy[b]  = n + cl + (!sd_we_n ? 2 : 1);
                  end
               end
            end
            4'b0001: begin
               tmax = 0;
               for (int i = 0; i < 4; i++) if (t_rdy[i] > tmax) tmax = t_rdy[i];
               check(opened == 4'b0 && n >= tmax, "R8 refresh with all banks idle", opened, 0);
               if (mrs_done) begin
                  n_ref++;
                  check(n - last_ref <= REFI + SLACK, "R8 refresh interval", n - last_ref, REFI + SLACK);
                  last_ref = n;
               end else init_refs++;
            end
            4'b0000: begin
               check(init_pre && init_refs >= 2, "R1 init order", init_refs, 2);
               check(sd_a[6:0] == 7'(cl << 4), "R1 mode word", sd_a[6:0], cl << 4);
               mrs_done = 1; last_ref = n;
            end
            default: check(0, "R10 illegal command code",
                           {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
         endcase
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic do_reset(input bit c3);
      @(negedge clk);
      rst_n = 0; cfg_cas3 = c3; cl = c3 ? 3 : 2;
      opened = '0; init_pre = 0; init_refs = 0; mrs_done = 0;
      for (int i = 0; i < 4; i++) begin t_rdy[i] = 0; t_act[i] = 0; orow[i] = 0; end
      acc_q.delete(); drv_q.delete(); rexp_q.delete(); rdue_q.delete();
      mem.delete(); shadow.delete();
      repeat (3) @(negedge clk);
      check(!ready && !rvalid && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && !sd_dq_oe,
            "R10 reset state", {ready, rvalid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 6'b000111);
      rst_n = 1;
      while (!ready) @(negedge clk);
   endtask

   task automatic host(input bit we, input bit ap, input int bank, input int row, input int col,
                       input logic [15:0] d, input logic [1:0] be);
      int ad;
      logic [15:0] v;
      ad = pack(bank, row, col);
      @(negedge clk);
      req = 1; req_we = we; req_ap = ap; req_addr = 23'(ad); req_wdata = d; req_be = be;
      while (!ready) @(negedge clk);
      acc_q.push_back('{we, ap, bank, row, col, d, be});
      v = shadow.exists(ad) ? shadow[ad] : dflt(ad);
      if (we) begin
         if (be[0]) v[7:0]  = d[7:0];
         if (be[1]) v[15:8] = d[15:8];
         shadow[ad] = v;
      end else rexp_q.push_back(v);
      @(negedge clk);
      req = 0;
   endtask

   task automatic drain();
      repeat (16) @(negedge clk);
   endtask

   task automatic directed(input bit c3);
      int a0, p0;
      do_reset(c3);
      a0 = n_act; p0 = n_pre;
      host(1, 0, 0, 5, 3, 16'h1234, 2'b11);
      host(0, 0, 0, 5, 3, 16'h0, 2'b00);
      drain();
      check(n_act - a0 == 1, "R5 open-row hit skips activate", n_act - a0, 1);
      host(1, 0, 1, 5, 3, 16'hABCD, 2'b01);
      host(0, 0, 1, 5, 3, 16'h0, 2'b00);
      host(1, 0, 3, 7, 9, 16'h5A00, 2'b10);
      host(0, 0, 3, 7, 9, 16'h0, 2'b00);
      drain();
      a0 = n_act; p0 = n_pre;
      host(0, 0, 0, 9, 7, 16'h0, 2'b00);
      drain();
      check(n_pre - p0 == 1 && n_act - a0 == 1, "R6 row miss precharges then activates",
            {n_pre - p0, n_act - a0}, {32'd1, 32'd1});
      a0 = n_act; p0 = n_pre;
      host(1, 1, 2, 1, 1, 16'hC3C3, 2'b11);
      host(0, 1, 2, 1, 1, 16'h0, 2'b00);
      host(0, 0, 2, 1, 1, 16'h0, 2'b00);
      drain();
      check(n_pre - p0 == 0 && n_act - a0 == 3, "R7 auto-precharge closes row without precharge",
            {n_pre - p0, n_act - a0}, {32'd0, 32'd3});
      check(rdue_q.size() == 0 && acc_q.size() == 0, "R11 all requests completed",
            rdue_q.size() + acc_q.size(), 0);
   endtask

   initial begin
      int x, r0;
      directed(0);
      directed(1);
      x  = 32'h1357;
      r0 = n_ref;
      for (int i = 0; i < 520; i++) begin
         x = x * 1103515245 + 12345;
         host(x[20], x[21] & x[22], x[9:8], x[11:10], x[15:12], x[31:16], x[7:6] | 2'b01);
      end
      drain();
      check(n_ref - r0 >= 2, "R8 refresh served under heavy host load", n_ref - r0, 2);
      r0 = n_ref;
      repeat (2 * REFI) @(negedge clk);
      check(n_ref - r0 >= 1, "R8 refresh runs while idle", n_ref - r0, 1);
      check(n - last_ref <= REFI + SLACK, "R8 final refresh gap", n - last_ref, REFI + SLACK);
      check(rdue_q.size() == 0 && acc_q.size() == 0, "R3 no reads left outstanding",
            rdue_q.size() + acc_q.size(), 0);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      check(0, "watchdog expired", 0, 1);
      finish_run();
   end
endmodule